// File: doc/BRIEF.md
# Real-Time Clock Register Block with Event and Error Interrupts

This block keeps a 32-bit count of seconds for a real-time clock. The count advances on a one-cycle tick enable that arrives once per second. A processor reaches the block through a word-wide register port made of valid, write, address, byte-enable and write data. Read data is a combinational function of the address. Besides the seconds count, the block holds an alarm compare value, a stored calibration word, a sub-second cycle counter, a control word and a scratch word.

The block drives two level interrupt lines. One reports clock events: a seconds increment and an alarm match. The other reports bad register accesses. Each line has a write-one-to-clear status register and a mask register that software cannot write directly. Two write-only strobe registers change the mask: one unmasks sources and the other masks them. Both masks come out of reset with every source masked.

Word offsets (byte address): 0x00 seconds, 0x04 set-time, 0x08 calibration, 0x0C sub-second tick, 0x10 alarm, 0x14 event status, 0x18 event mask, 0x1C event unmask, 0x20 event mask-set, 0x24 error status, 0x28 error mask, 0x2C error unmask, 0x30 error mask-set, 0x34 control, 0x38 scratch. Every byte address from 0x3C upward is unmapped.

Top module: `rtc_regblock`

## Requirements
- R1: The seconds count resets to 0 and rises by one on each tick where no load is pending. A read of offset 0x00 or offset 0x04 returns the live count.
- R2: A write to offset 0x04 does not change the count until the next tick. On that tick the count takes the written value instead of incrementing.
- R3: Event status bit 0 sets on every tick that increments the count. Bit 1 sets on a tick after which the count equals the alarm register at 0x10. Writing 1 to a bit of 0x14 clears that bit. A source event in the same cycle as a clear leaves the bit set.
- R4: The event mask at 0x18 resets to 0b11 and is read-only. Writes to 0x18 are ignored.
- R5: A write to 0x1C clears each event mask bit where the data is 1. A write to 0x20 sets each event mask bit where the data is 1. Both 0x1C and 0x20 read as zero.
- R6: `irq_evt` is high exactly when some event status bit is 1 while its mask bit is 0. It reflects a status or mask write from the cycle after that write.
- R7: An access is rejected when its offset is 0x3C or above, its address is not word aligned, or its byte enable is not 4'b1111. A rejected access sets error status bit 0. A rejected read returns zero and a rejected write changes no register. The error path has its own W1C status at 0x24, a read-only mask at 0x28 that resets to 1, unmask and mask-set strobes at 0x2C and 0x30, and output `irq_err`.
- R8: Offset 0x08 stores and returns the low 21 bits of the written data. Offset 0x0C returns the number of clock cycles since the last tick. That value is 0 right after a tick and saturates at its maximum.
- R9: The control word at 0x34 resets to 0x0100_0000. Bits in mask 0x70FF_FFFE read as zero and ignore writes. The scratch word at 0x38 and the alarm at 0x10 store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick enable, one cycle wide |
| req_valid | input | 1 | Register access valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for the addressed register |
| irq_evt | output | 1 | Clock event interrupt level |
| irq_err | output | 1 | Address error interrupt level |

## Verification
The bench builds the block with TICK_W set to 4, so the sub-second counter saturates at 15. Thirty idle cycles after a tick are then enough to check saturation; the default 16-bit width would need 65,535 cycles. The address width and the 21-bit calibration width keep their default values. Offsets 0x40 and 0x44 therefore exercise the unmapped range, while offsets 0x01 and 0x12 exercise misalignment inside the mapped range.

// File: rtl/rtc_regblock_pkg.sv
package rtc_regblock_pkg;
  localparam int NREG  = 15;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_SECONDS  = 4'd0;
  localparam logic [IDX_W-1:0] IDX_SETTIME  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_CALIB    = 4'd2;
  localparam logic [IDX_W-1:0] IDX_SUBSEC   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_ALARM    = 4'd4;
  localparam logic [IDX_W-1:0] IDX_EVT_STAT = 4'd5;
  localparam logic [IDX_W-1:0] IDX_EVT_MASK = 4'd6;
  localparam logic [IDX_W-1:0] IDX_EVT_UNM  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_EVT_MSET = 4'd8;
  localparam logic [IDX_W-1:0] IDX_ERR_STAT = 4'd9;
  localparam logic [IDX_W-1:0] IDX_ERR_MASK = 4'd10;
  localparam logic [IDX_W-1:0] IDX_ERR_UNM  = 4'd11;
  localparam logic [IDX_W-1:0] IDX_ERR_MSET = 4'd12;
  localparam logic [IDX_W-1:0] IDX_CONTROL  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_SCRATCH  = 4'd14;

  localparam logic [31:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [31:0] CTRL_RSVD  = 32'h70FF_FFFE;

  localparam int EVT_N = 2;
  localparam int EVT_BIT_SEC   = 0;
  localparam int EVT_BIT_ALARM = 1;
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_regblock_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mapped_o,
  output logic              bad_o,
  output logic [NREG-1:0]   wr_stb_o
);
  localparam int LOW_W = IDX_W + 2;

  logic upper_nz;
  logic in_range;

  generate
    if (ADDR_W > LOW_W) begin : g_upper
      assign upper_nz = |addr_i[ADDR_W-1:LOW_W];
    end else begin : g_no_upper
      assign upper_nz = 1'b0;
    end
  endgenerate

  assign idx_o    = addr_i[LOW_W-1:2];
  assign in_range = !upper_nz && (int'(idx_o) < NREG);
  assign mapped_o = in_range && (addr_i[1:0] == 2'b00) && (be_i == 4'hF);
  assign bad_o    = valid_i && !mapped_o;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_stb
      assign wr_stb_o[i] = valid_i && write_i && mapped_o && (idx_o == IDX_W'(i));
    end
  endgenerate
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic         unmask_we,
  input  logic         maskset_we,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, status_n;
  logic [N-1:0] mask_q, mask_n;

  always_comb begin
    status_n = status_q;
    if (clr_we) status_n = status_n & ~wdata_i;
    status_n = status_n | set_i;
    mask_n = mask_q;
    if (unmask_we)  mask_n = mask_n & ~wdata_i;
    if (maskset_we) mask_n = mask_n | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  // R5 (event path) and R7 (error path) share these checks
  assert_unmask_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_we && !maskset_we |=> (mask_o & $past(wdata_i)) == '0);
  assert_maskset_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    maskset_we |=> (mask_o & $past(wdata_i)) == $past(wdata_i));
  assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && (set_i == '0) |=> (status_o & $past(wdata_i)) == '0);
  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> (status_o & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_we,
  input  logic [31:0]       load_val,
  input  logic [31:0]       alarm_i,
  output logic [31:0]       secs_o,
  output logic [TICK_W-1:0] sub_o,
  output logic              inc_evt_o,
  output logic              alarm_evt_o
);
  localparam logic [TICK_W-1:0] SUB_MAX = '1;

  logic [31:0]       secs_q, secs_n, secs_step;
  logic [31:0]       pend_val_q, pend_val_n;
  logic              pend_q, pend_n;
  logic [TICK_W-1:0] sub_q, sub_n;

  assign secs_step = pend_q ? pend_val_q : secs_q + 32'd1;

  always_comb begin
    secs_n     = tick_i ? secs_step : secs_q;
    pend_val_n = load_we ? load_val : pend_val_q;
    pend_n     = load_we ? 1'b1 : (tick_i ? 1'b0 : pend_q);
    if (tick_i)               sub_n = '0;
    else if (sub_q != SUB_MAX) sub_n = sub_q + 1'b1;
    else                       sub_n = sub_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q     <= '0;
      pend_val_q <= '0;
      pend_q     <= 1'b0;
      sub_q      <= '0;
    end else begin
      secs_q     <= secs_n;
      pend_val_q <= pend_val_n;
      pend_q     <= pend_n;
      sub_q      <= sub_n;
    end
  end

  assign secs_o      = secs_q;
  assign sub_o       = sub_q;
  assign inc_evt_o   = tick_i && !pend_q;
  assign alarm_evt_o = tick_i && (secs_step == alarm_i);

  assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !pend_q |=> secs_o == $past(secs_o) + 32'd1);
  assert_load_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && pend_q |=> secs_o == $past(pend_val_q));
  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(secs_o));
  assert_sub_zero_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> sub_o == '0);
endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
  import rtc_regblock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TICK_W = 16,
  parameter int CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       req_rdata,
  output logic              irq_evt,
  output logic              irq_err
);
  logic [IDX_W-1:0]  idx;
  logic              mapped, acc_bad;
  logic [NREG-1:0]   wr_stb;

  logic [31:0]       secs;
  logic [TICK_W-1:0] sub;
  logic              inc_evt, alarm_evt;

  logic [CAL_W-1:0]  cal_q, cal_n;
  logic [31:0]       alarm_q, alarm_n;
  logic [31:0]       ctrl_q, ctrl_n;
  logic [31:0]       scratch_q, scratch_n;

  logic [EVT_N-1:0]  evt_status, evt_mask, evt_set;
  logic [0:0]        err_status, err_mask;

  rtc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i  (req_valid),
    .write_i  (req_write),
    .addr_i   (req_addr),
    .be_i     (req_be),
    .idx_o    (idx),
    .mapped_o (mapped),
    .bad_o    (acc_bad),
    .wr_stb_o (wr_stb)
  );

  rtc_seconds_core #(.TICK_W(TICK_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .load_we     (wr_stb[IDX_SETTIME]),
    .load_val    (req_wdata),
    .alarm_i     (alarm_q),
    .secs_o      (secs),
    .sub_o       (sub),
    .inc_evt_o   (inc_evt),
    .alarm_evt_o (alarm_evt)
  );

  always_comb begin
    evt_set = '0;
    evt_set[EVT_BIT_SEC]   = inc_evt;
    evt_set[EVT_BIT_ALARM] = alarm_evt;
  end

  rtc_irq_unit #(.N(EVT_N)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_we     (wr_stb[IDX_EVT_STAT]),
    .unmask_we  (wr_stb[IDX_EVT_UNM]),
    .maskset_we (wr_stb[IDX_EVT_MSET]),
    .wdata_i    (req_wdata[EVT_N-1:0]),
    .status_o   (evt_status),
    .mask_o     (evt_mask),
    .irq_o      (irq_evt)
  );

  rtc_irq_unit #(.N(1)) u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (acc_bad),
    .clr_we     (wr_stb[IDX_ERR_STAT]),
    .unmask_we  (wr_stb[IDX_ERR_UNM]),
    .maskset_we (wr_stb[IDX_ERR_MSET]),
    .wdata_i    (req_wdata[0:0]),
    .status_o   (err_status),
    .mask_o     (err_mask),
    .irq_o      (irq_err)
  );

  always_comb begin
    cal_n     = wr_stb[IDX_CALIB]   ? req_wdata[CAL_W-1:0] : cal_q;
    alarm_n   = wr_stb[IDX_ALARM]   ? req_wdata : alarm_q;
    ctrl_n    = wr_stb[IDX_CONTROL] ? (req_wdata & ~CTRL_RSVD) : ctrl_q;
    scratch_n = wr_stb[IDX_SCRATCH] ? req_wdata : scratch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q     <= '0;
      alarm_q   <= '0;
      ctrl_q    <= CTRL_RESET;
      scratch_q <= '0;
    end else begin
      cal_q     <= cal_n;
      alarm_q   <= alarm_n;
      ctrl_q    <= ctrl_n;
      scratch_q <= scratch_n;
    end
  end

  always_comb begin
    req_rdata = '0;
    if (mapped) begin
      unique case (idx)
        IDX_SECONDS, IDX_SETTIME: req_rdata = secs;
        IDX_CALIB:    req_rdata = {{(32-CAL_W){1'b0}}, cal_q};
        IDX_SUBSEC:   req_rdata = {{(32-TICK_W){1'b0}}, sub};
        IDX_ALARM:    req_rdata = alarm_q;
        IDX_EVT_STAT: req_rdata = {{(32-EVT_N){1'b0}}, evt_status};
        IDX_EVT_MASK: req_rdata = {{(32-EVT_N){1'b0}}, evt_mask};
        IDX_ERR_STAT: req_rdata = {31'd0, err_status};
        IDX_ERR_MASK: req_rdata = {31'd0, err_mask};
        IDX_CONTROL:  req_rdata = ctrl_q;
        IDX_SCRATCH:  req_rdata = scratch_q;
        default:      req_rdata = '0;
      endcase
    end
  end

  assert_bad_access_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> err_status[0]);
  assert_bad_write_keeps_scratch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> $stable(scratch_q));
  assert_ctrl_write_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[IDX_CONTROL] |=> ctrl_q == ($past(req_wdata) & ~CTRL_RSVD));
endmodule

// File: tb/rtc_regblock_test.sv
module rtc_regblock_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [31:0] req_rdata;
  logic        irq_evt;
  logic        irq_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_regblock #(.ADDR_W(8), .TICK_W(4), .CAL_W(21)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .irq_evt(irq_evt), .irq_err(irq_err)
  );

  // layout: [76] write, [75:68] addr, [67:36] data, [35:4] expected, [3:0] requirement
  localparam int NV = 19;
  localparam logic [76:0] VEC [0:NV-1] = '{
    {1'b0, 8'h18, 32'h0,        32'h0000_0003, 4'd4}, // R4 mask reset
    {1'b0, 8'h28, 32'h0,        32'h0000_0001, 4'd7}, // R7 error mask reset
    {1'b0, 8'h34, 32'h0,        32'h0100_0000, 4'd9}, // R9 control reset
    {1'b1, 8'h34, 32'hFFFF_FFFF, 32'h0,        4'd9},
    {1'b0, 8'h34, 32'h0,        32'h8F00_0001, 4'd9}, // R9 reserved bits
    {1'b1, 8'h18, 32'h0,        32'h0,         4'd4},
    {1'b0, 8'h18, 32'h0,        32'h0000_0003, 4'd4}, // R4 read-only mask
    {1'b1, 8'h1C, 32'h1,        32'h0,         4'd5},
    {1'b0, 8'h18, 32'h0,        32'h0000_0002, 4'd5}, // R5 unmask
    {1'b0, 8'h1C, 32'h0,        32'h0,         4'd5}, // R5 strobe reads zero
    {1'b1, 8'h20, 32'h1,        32'h0,         4'd5},
    {1'b0, 8'h18, 32'h0,        32'h0000_0003, 4'd5}, // R5 mask-set
    {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,        4'd8},
    {1'b0, 8'h08, 32'h0,        32'h001F_FFFF, 4'd8}, // R8 calibration
    {1'b1, 8'h10, 32'hDEAD_BEEF, 32'h0,        4'd9},
    {1'b0, 8'h10, 32'h0,        32'hDEAD_BEEF, 4'd9}, // R9 alarm
    {1'b1, 8'h38, 32'h1234_5678, 32'h0,        4'd9},
    {1'b0, 8'h38, 32'h0,        32'h1234_5678, 4'd9}, // R9 scratch
    {1'b0, 8'h24, 32'h0,        32'h0,         4'd7}  // R7 no error yet
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    #1 d = req_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic tick();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; tick_i = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = 4'hF; req_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(8'h00, d); chk("R1 reset count", d, 32'd0);
    rd(8'h14, d); chk("R3 reset status", d, 32'd0);
    chk("R6 reset irq_evt", {31'd0, irq_evt}, 32'd0);
    chk("R7 reset irq_err", {31'd0, irq_err}, 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][75:68], d);
        checks++;
        if (d !== VEC[i][35:4]) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual 0x%08h expected 0x%08h",
                   VEC[i][3:0], i, d, VEC[i][35:4]);
        end
      end
    end

    // R1 counting
    tick(); tick(); tick();
    rd(8'h00, d); chk("R1 count after 3 ticks", d, 32'd3);
    rd(8'h04, d); chk("R1 set-time readback", d, 32'd3);
    rd(8'h14, d); chk("R3 increment flag", d, 32'd1);
    wr(8'h14, 32'h1);
    rd(8'h14, d); chk("R3 w1c", d, 32'd0);

    // R2 deferred load
    wr(8'h04, 32'd100);
    rd(8'h00, d); chk("R2 load deferred", d, 32'd3);
    tick();
    rd(8'h00, d); chk("R2 load on tick", d, 32'd100);
    rd(8'h14, d); chk("R3 load sets no flag", d, 32'd0);

    // R3 alarm
    wr(8'h10, 32'd102);
    tick();
    rd(8'h14, d); chk("R3 no alarm at 101", d, 32'd1);
    tick();
    rd(8'h14, d); chk("R3 alarm at 102", d, 32'd3);
    chk("R6 masked irq", {31'd0, irq_evt}, 32'd0);

    // R6 interrupt level
    wr(8'h1C, 32'h2);
    chk("R6 irq after unmask", {31'd0, irq_evt}, 32'd1);
    wr(8'h14, 32'h2);
    chk("R6 irq after clear", {31'd0, irq_evt}, 32'd0);
    wr(8'h1C, 32'h1);
    chk("R6 irq bit0", {31'd0, irq_evt}, 32'd1);
    wr(8'h20, 32'h3);
    chk("R6 irq after mask-set", {31'd0, irq_evt}, 32'd0);
    rd(8'h18, d); chk("R5 mask all set", d, 32'd3);

    // R3 set wins over clear in the same cycle
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h14; req_wdata = 32'h3; req_be = 4'hF;
    tick_i = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick_i = 1'b0;
    rd(8'h14, d); chk("R3 set wins", d, 32'd1);

    // R8 sub-second counter
    tick();
    idle(5);
    rd(8'h0C, d); chk("R8 cycles since tick", d, 32'd5);
    tick();
    rd(8'h0C, d); chk("R8 zero after tick", d, 32'd0);
    idle(30);
    rd(8'h0C, d); chk("R8 saturate", d, 32'd15);

    // R7 address errors
    rd(8'h40, d); chk("R7 unmapped read zero", d, 32'd0);
    rd(8'h24, d); chk("R7 error flagged", d, 32'd1);
    chk("R7 irq_err masked", {31'd0, irq_err}, 32'd0);
    wr(8'h2C, 32'h1);
    chk("R7 irq_err unmasked", {31'd0, irq_err}, 32'd1);
    wr(8'h24, 32'h1);
    chk("R7 irq_err cleared", {31'd0, irq_err}, 32'd0);
    rd(8'h01, d); chk("R7 misaligned read zero", d, 32'd0);
    chk("R7 irq_err on misaligned", {31'd0, irq_err}, 32'd1);
    wr(8'h24, 32'h1);
    wr(8'h12, 32'h0);
    rd(8'h10, d); chk("R7 misaligned write ignored", d, 32'd102);
    wr(8'h38, 32'h0, 4'h3);
    rd(8'h38, d); chk("R7 partial write ignored", d, 32'h1234_5678);
    wr(8'h44, 32'h0);
    rd(8'h38, d); chk("R7 unmapped write ignored", d, 32'h1234_5678);
    rd(8'h24, d); chk("R7 status after bad writes", d, 32'd1);
    wr(8'h30, 32'h1);
    chk("R7 irq_err after mask-set", {31'd0, irq_err}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule